// File: doc/BRIEF.md
# Two-Step Filter Calibration Sequencer

This block sets the corner frequency of a continuous-time active filter whose capacitors are switched arrays. It first trims a reference resistor code. It then runs a coarse search on a short capacitor code, and finally steps a fine op-amp bias code that feeds an external DAC. Every decision comes from a single-bit result of an external analog comparator. The block also produces the two non-overlapping measurement phases. Phase 0 charges a replica integrator, and the comparator outputs are taken at the end of the phase-1 cycle.

A one-cycle `start` pulse clears every code, flag and error and begins the sequence at the resistor trim. The sequence moves forward one step per measurement: reference trim, then coarse capacitor search, then fine bias search. When the fine loop has settled, `done` rises and the phase outputs go quiet. The codes stay on the output ports for the analog side to use.

Top module: `filt_cal_seq`

## Requirements
- R1: After reset, and after each `start` pulse, the codes read ref_code=4, cap_code=2 and bias_code=32 (mid-scale). All lock flags, `done` and `cal_err` are low. After reset, `ph0` and `ph1` stay low until the first `start`.
- R2: While running, `ph0` is high for `ph0_len_m1`+1 cycles. One cycle follows with both phases low, then `ph1` is high for one cycle, and the pattern repeats. The two phases are never high together, and both are low in idle and after `done`.
- R3: During reference trim, each measurement raises ref_code by one when `cmp_bias_hi` is 1 and lowers it by one when it is 0.
- R4: Reference trim ends at the first measurement whose `cmp_bias_hi` differs from the previous measurement's. That measurement sets `ref_lock` and does not change ref_code. cap_code does not move before `ref_lock` is set.
- R5: During the coarse phase, cap_code rises by one when `cmp_rep_above_hi` is 1. Otherwise it falls by one when `cmp_rep_below_lo` is 1; above-high has priority.
- R6: A coarse measurement with both window comparators at 0 sets `coarse_lock`, leaves cap_code unchanged and hands over to the fine phase.
- R7: During the fine phase, bias_code rises by one when `cmp_rep_above_mid` is 1 and falls by one when it is 0.
- R8: The fine loop locks on the second consecutive measurement whose `cmp_rep_above_mid` differs from the one before it. That measurement sets `fine_lock` and `done` and does not change bias_code.
- R9: Every code saturates at 0 and at its all-ones value and never wraps. Each change is exactly one step.
- R10: When a code's requested step is blocked by saturation on 8 consecutive measurements of its phase, `cal_err` rises. It stays high until the next `start`.
- R11: Comparator inputs pass through two synchronizing flops, and a decision is taken once per measurement, at the clock edge that ends the `ph1` cycle. A comparator change made less than two cycles before that edge is not used. Codes change only at such an edge or at `start`.
- R12: A `start` pulse in the middle of a run restarts the sequence at reference trim with default codes and a cleared error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that restarts calibration |
| ph0_len_m1 | input | DIV_W | Phase-0 high time minus one, in clock cycles |
| cmp_bias_hi | input | 1 | Reference comparator: 1 when bias is above reference |
| cmp_rep_above_hi | input | 1 | Replica output above the high threshold |
| cmp_rep_below_lo | input | 1 | Replica output below the low threshold |
| cmp_rep_above_mid | input | 1 | Replica output above the mid threshold |
| ph0 | output | 1 | Replica charge phase |
| ph1 | output | 1 | Comparator sample phase |
| ref_code | output | REF_W | Reference resistor trim code |
| cap_code | output | CAP_W | Coarse capacitor array code |
| bias_code | output | BIAS_W | Fine op-amp bias DAC code |
| ref_lock | output | 1 | Reference trim finished |
| coarse_lock | output | 1 | Coarse capacitor search finished |
| fine_lock | output | 1 | Fine bias search finished |
| done | output | 1 | Calibration complete |
| cal_err | output | 1 | Some code stayed stuck at a limit |

## Verification
On every cycle, the assertions check the following:
- the two phases never overlap, and each `ph1` pulse follows a gap cycle;
- each code moves by at most one step and only at a sample edge or at `start`;
- the capacitor code stays frozen until the reference lock;
- the lock flags appear in phase order;
- the error flag is sticky.

The actual direction of each step cannot be shown by those assertions; only the bench's measurement sequences can show it. The same holds for the following:
- the exact measurement on which each phase locks;
- the toggle count that ends the fine loop;
- the eighth blocked step that raises the error;
- the rule that a late comparator change is ignored.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_COARSE,
    ST_FINE,
    ST_DONE
  } cal_state_e;

endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/cal_phase_gen.sv
module cal_phase_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] len_m1,
  output logic             ph0,
  output logic             ph1
);

  localparam int CW = DIV_W + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [CW-1:0] cnt_nx;

  // position len_m1+1 is the gap, len_m1+2 is the sample phase
  always_comb begin
    last   = CW'(len_m1) + CW'(2);
    cnt_nx = (cnt >= last) ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ph0 <= 1'b0;
      ph1 <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ph0 <= 1'b1;
      ph1 <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      ph0 <= 1'b0;
      ph1 <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      ph0 <= (cnt_nx <= CW'(len_m1));
      ph1 <= (cnt_nx == last);
    end
  end

  p_ph_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(ph0 && ph1));

  p_ph1_gap_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ph1) |-> !$past(ph0));

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> (!ph0 && !ph1));

endmodule

// File: rtl/cal_sat_step.sv
module cal_sat_step #(
  parameter int W         = 3,
  parameter int RST_VAL   = 4,
  parameter int STUCK_LIM = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         up,
  output logic [W-1:0] code,
  output logic         stuck
);

  localparam int CNT_W = $clog2(STUCK_LIM + 1);
  localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

  logic [CNT_W-1:0] blk_cnt;
  logic             at_lim;

  always_comb begin
    at_lim = up ? (code == CODE_MAX) : (code == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code    <= W'(RST_VAL);
      blk_cnt <= '0;
      stuck   <= 1'b0;
    end else if (en) begin
      if (at_lim) begin
        if (blk_cnt != CNT_W'(STUCK_LIM)) blk_cnt <= blk_cnt + CNT_W'(1);
        if (blk_cnt == CNT_W'(STUCK_LIM - 1)) stuck <= 1'b1;
      end else begin
        code    <= up ? code + W'(1) : code - W'(1);
        blk_cnt <= '0;
      end
    end
  end

  p_step_one_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && !$stable(code)) |->
      (({1'b0, code} == {1'b0, $past(code)} + (W+1)'(1)) ||
       ({1'b0, code} + (W+1)'(1) == {1'b0, $past(code)})));

  p_stuck_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (stuck && !clr) |=> stuck);

endmodule

// File: rtl/filt_cal_seq.sv
module filt_cal_seq
  import cal_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int REF_W     = 3,
  parameter int CAP_W     = 2,
  parameter int BIAS_W    = 6,
  parameter int STUCK_LIM = 8,
  parameter int TOG_LOCK  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DIV_W-1:0]  ph0_len_m1,
  input  logic              cmp_bias_hi,
  input  logic              cmp_rep_above_hi,
  input  logic              cmp_rep_below_lo,
  input  logic              cmp_rep_above_mid,
  output logic              ph0,
  output logic              ph1,
  output logic [REF_W-1:0]  ref_code,
  output logic [CAP_W-1:0]  cap_code,
  output logic [BIAS_W-1:0] bias_code,
  output logic              ref_lock,
  output logic              coarse_lock,
  output logic              fine_lock,
  output logic              done,
  output logic              cal_err
);

  localparam int REF_MID  = 1 << (REF_W - 1);
  localparam int CAP_MID  = 1 << (CAP_W - 1);
  localparam int BIAS_MID = 1 << (BIAS_W - 1);
  localparam int TOG_W    = $clog2(TOG_LOCK + 1);

  cal_state_e       state;
  logic [3:0]       cmp_s;
  logic             s_bias, s_hi, s_lo, s_mid;
  logic             samp;
  logic             ref_seen, ref_prev, fine_seen, fine_prev;
  logic [TOG_W-1:0] tog_cnt;
  logic             ref_flip, ref_en;
  logic             win_ok, cap_en;
  logic             fine_tog, fine_hit, bias_en;
  logic             run;
  logic [2:0]       stuck;

  cal_sync #(.N(4)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cmp_bias_hi, cmp_rep_above_hi, cmp_rep_below_lo, cmp_rep_above_mid}),
    .q   (cmp_s)
  );

  assign {s_bias, s_hi, s_lo, s_mid} = cmp_s;

  // decisions happen on the edge that closes the phase-1 cycle
  assign samp = ph1;

  always_comb begin
    ref_flip = samp && (state == ST_REF) && ref_seen && (s_bias != ref_prev);
    ref_en   = samp && (state == ST_REF) && !ref_flip;
    win_ok   = !s_hi && !s_lo;
    cap_en   = samp && (state == ST_COARSE) && !win_ok;
    fine_tog = fine_seen && (s_mid != fine_prev);
    fine_hit = samp && (state == ST_FINE) && fine_tog &&
               (tog_cnt == TOG_W'(TOG_LOCK - 1));
    bias_en  = samp && (state == ST_FINE) && !fine_hit;
    run      = ((state == ST_REF) || (state == ST_COARSE) || (state == ST_FINE)) &&
               !fine_hit;
  end

  cal_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .run    (run),
    .len_m1 (ph0_len_m1),
    .ph0    (ph0),
    .ph1    (ph1)
  );

  cal_sat_step #(.W(REF_W), .RST_VAL(REF_MID), .STUCK_LIM(STUCK_LIM)) u_ref_step (
    .clk (clk), .rst (rst), .clr (start),
    .en  (ref_en), .up (s_bias),
    .code (ref_code), .stuck (stuck[0])
  );

  cal_sat_step #(.W(CAP_W), .RST_VAL(CAP_MID), .STUCK_LIM(STUCK_LIM)) u_cap_step (
    .clk (clk), .rst (rst), .clr (start),
    .en  (cap_en), .up (s_hi),
    .code (cap_code), .stuck (stuck[1])
  );

  cal_sat_step #(.W(BIAS_W), .RST_VAL(BIAS_MID), .STUCK_LIM(STUCK_LIM)) u_bias_step (
    .clk (clk), .rst (rst), .clr (start),
    .en  (bias_en), .up (s_mid),
    .code (bias_code), .stuck (stuck[2])
  );

  assign cal_err = |stuck;
  assign done    = fine_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ref_seen    <= 1'b0;
      ref_prev    <= 1'b0;
      fine_seen   <= 1'b0;
      fine_prev   <= 1'b0;
      tog_cnt     <= '0;
      ref_lock    <= 1'b0;
      coarse_lock <= 1'b0;
      fine_lock   <= 1'b0;
    end else if (start) begin
      state       <= ST_REF;
      ref_seen    <= 1'b0;
      ref_prev    <= 1'b0;
      fine_seen   <= 1'b0;
      fine_prev   <= 1'b0;
      tog_cnt     <= '0;
      ref_lock    <= 1'b0;
      coarse_lock <= 1'b0;
      fine_lock   <= 1'b0;
    end else if (samp) begin
      case (state)
        ST_REF: begin
          if (ref_flip) begin
            ref_lock <= 1'b1;
            state    <= ST_COARSE;
          end else begin
            ref_prev <= s_bias;
            ref_seen <= 1'b1;
          end
        end
        ST_COARSE: begin
          if (win_ok) begin
            coarse_lock <= 1'b1;
            state       <= ST_FINE;
          end
        end
        ST_FINE: begin
          fine_prev <= s_mid;
          fine_seen <= 1'b1;
          if (fine_tog) tog_cnt <= tog_cnt + TOG_W'(1);
          else          tog_cnt <= '0;
          if (fine_hit) begin
            fine_lock <= 1'b1;
            state     <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  p_cap_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !ref_lock |-> (cap_code == CAP_W'(CAP_MID)));

  p_coarse_after_ref_r6: assert property (@(posedge clk) disable iff (rst)
    coarse_lock |-> ref_lock);

  p_done_locks_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (ref_lock && coarse_lock && fine_lock));

  p_bias_on_sample_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(bias_code) |-> ($past(ph1) || $past(start)));

  p_ref_on_sample_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_code) |-> ($past(ph1) || $past(start)));

  p_cap_on_sample_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_code) |-> ($past(ph1) || $past(start)));

endmodule

// File: tb/filt_cal_seq_tb.sv
`timescale 1ns/1ps
module filt_cal_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] ph0_len_m1 = 8'd1;
  logic       c_bias = 1'b0, c_hi = 1'b0, c_lo = 1'b0, c_mid = 1'b0;
  logic       ph0, ph1;
  logic [2:0] ref_code;
  logic [1:0] cap_code;
  logic [5:0] bias_code;
  logic       ref_lock, coarse_lock, fine_lock, done, cal_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  filt_cal_seq u_dut (
    .clk (clk), .rst (rst), .start (start), .ph0_len_m1 (ph0_len_m1),
    .cmp_bias_hi (c_bias), .cmp_rep_above_hi (c_hi),
    .cmp_rep_below_lo (c_lo), .cmp_rep_above_mid (c_mid),
    .ph0 (ph0), .ph1 (ph1),
    .ref_code (ref_code), .cap_code (cap_code), .bias_code (bias_code),
    .ref_lock (ref_lock), .coarse_lock (coarse_lock), .fine_lock (fine_lock),
    .done (done), .cal_err (cal_err)
  );

  // entry: {cmp[3:0] = bias_hi,above_hi,below_lo,above_mid, ref[2:0], cap[1:0], bias[5:0], locks[2:0]}
  localparam logic [17:0] VEC [13] = '{
    {4'b1000, 3'd5, 2'd2, 6'd32, 3'b000},  // R3 up
    {4'b1000, 3'd6, 2'd2, 6'd32, 3'b000},  // R3 up
    {4'b0000, 3'd6, 2'd2, 6'd32, 3'b100},  // R4 sign change
    {4'b0100, 3'd6, 2'd3, 6'd32, 3'b100},  // R5 up
    {4'b0100, 3'd6, 2'd3, 6'd32, 3'b100},  // R9 saturate high
    {4'b0010, 3'd6, 2'd2, 6'd32, 3'b100},  // R5 down
    {4'b0000, 3'd6, 2'd2, 6'd32, 3'b110},  // R6 window
    {4'b0001, 3'd6, 2'd2, 6'd33, 3'b110},  // R7 up
    {4'b0001, 3'd6, 2'd2, 6'd34, 3'b110},  // R7 up
    {4'b0000, 3'd6, 2'd2, 6'd33, 3'b110},  // R8 toggle 1
    {4'b0000, 3'd6, 2'd2, 6'd32, 3'b110},  // R8 no toggle
    {4'b0001, 3'd6, 2'd2, 6'd33, 3'b110},  // R8 toggle 1
    {4'b0000, 3'd6, 2'd2, 6'd33, 3'b111}   // R8 toggle 2 -> lock
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // wait for the sample phase, optionally flip bias comparator late, then pass the decision edge
  task automatic do_meas(input bit late_flip, input bit late_val);
    int guard = 0;
    while (ph1 !== 1'b1 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    if (late_flip) c_bias = late_val;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 ref_code", ref_code, 4);
    chk("R1 cap_code", cap_code, 2);
    chk("R1 bias_code", bias_code, 32);
    chk("R1 locks", {ref_lock, coarse_lock, fine_lock, done, cal_err}, 0);
    chk("R1 phases idle", {ph0, ph1}, 0);

    // R2 phase timing with ph0 length 3
    ph0_len_m1 = 8'd2;
    pulse_start();
    c0 = 0;
    while (ph0 && c0 < 100) begin
      if (ph1) chk("R2 overlap", 1, 0);
      c0++;
      @(negedge clk);
    end
    chk("R2 ph0 length", c0, 3);
    chk("R2 gap cycle", {ph0, ph1}, 0);
    @(negedge clk);
    chk("R2 ph1 high", {ph0, ph1}, 1);
    @(negedge clk);
    chk("R2 ph0 again", {ph0, ph1}, 2);

    // table run, R3..R9
    ph0_len_m1 = 8'd1;
    pulse_start();
    for (int i = 0; i < 13; i++) begin
      {c_bias, c_hi, c_lo, c_mid} = VEC[i][17:14];
      do_meas(1'b0, 1'b0);
      chk($sformatf("R3 R4 R5 R6 R7 R8 R9 vector %0d", i),
          {ref_code, cap_code, bias_code, ref_lock, coarse_lock, fine_lock},
          int'(VEC[i][13:0]));
    end
    chk("R8 done", done, 1);
    repeat (6) begin
      @(negedge clk);
      chk("R2 quiet after done", {ph0, ph1}, 0);
    end
    chk("R8 bias held", bias_code, 33);

    // R9 and R10: drive ref code down into the floor
    {c_bias, c_hi, c_lo, c_mid} = 4'b0000;
    pulse_start();
    chk("R1 start defaults", {ref_code, cap_code, bias_code}, {3'd4, 2'd2, 6'd32});
    chk("R1 start flags", {ref_lock, coarse_lock, fine_lock, done}, 0);
    for (int i = 0; i < 11; i++) do_meas(1'b0, 1'b0);
    chk("R9 ref floor", ref_code, 0);
    chk("R10 no err after 7 blocked", cal_err, 0);
    do_meas(1'b0, 1'b0);
    chk("R10 err after 8 blocked", cal_err, 1);
    chk("R9 ref still floor", ref_code, 0);
    repeat (10) @(negedge clk);
    chk("R10 err sticky", cal_err, 1);

    // R12 restart mid-run, then R11 late comparator change
    c_bias = 1'b1;
    pulse_start();
    chk("R12 err cleared", cal_err, 0);
    chk("R12 ref default", ref_code, 4);
    chk("R12 no lock", ref_lock, 0);
    do_meas(1'b1, 1'b0);
    chk("R11 late change ignored", ref_code, 5);
    chk("R11 no lock yet", ref_lock, 0);
    do_meas(1'b0, 1'b0);
    chk("R4 lock on crossing", {ref_lock, 3'(ref_code)}, {1'b1, 3'd5});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule